// File: doc/BRIEF.md
# Single-Segment Block DMA Channel

This block is the built-in data mover of a storage host controller. It carries one contiguous buffer between system memory and the controller's data FIFO, in either direction. Software sets a mode word (direction, beat width, address stepping) and a start address that is split into a low and a high 32-bit word. It then writes a start bit. The channel issues one memory access per beat over a simple request/acknowledge port. It moves each beat to or from the FIFO over a valid/ready port. After the last beat it raises a one-cycle done pulse.

The host controller supplies the transfer length as a block count and a block size in bytes. The number of beats is that product divided by the beat size. A pair of channel-reset bits lets software abort a transfer: clearing them stops the channel, and setting them again releases it.

Top module: `blkdma_chan`

## Requirements
- R1: After reset the engine is idle and drives no memory request, no FIFO valid and no done. Register reads give mode = 0, busy = 0 and the reset register = 0x0000_0300.
- R2: The mode register is at word address 0, and its field [17:16] selects the direction. The value 1 moves data from the FIFO input (fifo_in) to memory writes (mem_we = 1). Any other value moves data from memory reads (mem_we = 0) to the FIFO output (fifo_out). Only one of mem_req, fifo_out_valid and fifo_in_ready is high in any cycle.
- R3: Mode field [5:4] selects the beat width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. mem_size carries this code on every access. A transfer has blk_count*blk_size/bytes beats. Mode reads return only bits 17:16, 5:4 and 0.
- R4: When mode bit 0 is 1, the address advances by the beat size in bytes after each memory beat. When bit 0 is 0, every beat uses the same address.
- R5: The start address is taken from word address 3 (bits 31:0) and word address 4 (bits 63:32). Address bits below the beat size are ignored, so the first beat goes to the start address rounded down to a beat boundary.
- R6: The control register is at word address 1. Writing it with bit 0 = 1 starts a transfer, and bit 0 always reads back as 0. Bit 1 reads 1 while a transfer is running.
- R7: A start write while busy is ignored. Mode and address writes during a transfer do not change the running transfer. Each start produces exactly one done.
- R8: A memory request keeps its address, direction and write data stable until mem_ack. FIFO output data stays valid and stable until fifo_out_ready. Each beat makes exactly one memory access.
- R9: done is high for one cycle. It comes in the cycle after the last beat's final handshake, and busy is already low in that cycle.
- R10: A start with blk_count*blk_size = 0 raises done in the cycle after the start write, with no memory or FIFO activity.
- R11: The channel-reset register is at word address 2, and it is read and written through bits 9 and 8. While either bit is 0 the channel is held. A running transfer is idle one cycle after the hold takes effect, with no done, and start writes are ignored during the hold. Setting both bits again lets new transfers run normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address, used for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr (combinational) |
| blk_count | input | CNT_W | Number of blocks in the transfer |
| blk_size | input | BSZ_W | Bytes per block |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_size | output | 2 | Beat width code |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |
| mem_ack | input | 1 | Completes the current request |
| fifo_out_valid | output | 1 | Beat offered to the FIFO |
| fifo_out_ready | input | 1 | FIFO accepts the beat |
| fifo_out_data | output | DATA_W | Beat data to the FIFO |
| fifo_in_valid | input | 1 | FIFO offers a beat |
| fifo_in_ready | output | 1 | Channel accepts a beat |
| fifo_in_data | input | DATA_W | Beat data from the FIFO |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |

## Verification
The hardest condition to reach from the ports is a channel hold that lands in the middle of a long transfer. It must arrive while a memory request or FIFO handshake is still open, and the check must show that no done ever follows. The bench starts a 2048-beat transfer against a memory model with varying latency and a stalling FIFO sink, clears the reset bits after twenty cycles, and then counts done pulses and watches busy and mem_req. It also tries a start while only one reset bit is clear. A similar situation is a transfer disturbed by a second start and by fresh mode and address writes while it runs; the bench shows it is unaffected by comparing every logged beat address with the values from before the disturbance.

// File: rtl/blkdma_pkg.sv
// Package: shared register addresses, mode layout and sequencer states for
// the single-segment DMA channel. Assumes a 3-bit word register address.
package blkdma_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] REG_MODE = 3'd0;
    localparam logic [REG_AW-1:0] REG_CTRL = 3'd1;
    localparam logic [REG_AW-1:0] REG_RST  = 3'd2;
    localparam logic [REG_AW-1:0] REG_LO   = 3'd3;
    localparam logic [REG_AW-1:0] REG_HI   = 3'd4;

    typedef struct packed {
        logic [1:0] dir;
        logic [1:0] width;
        logic       inc;
    } mode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_PUSH,
        ST_PULL,
        ST_WR_REQ
    } seq_state_t;

endpackage

// File: rtl/blkdma_regs.sv
// Register file: holds mode, start address words and the two channel-reset
// bits. Decodes the self-clearing start strobe and the channel hold.
// Assumes ADDR_W between 33 and 64; reads are combinational on wr_addr.
module blkdma_regs
    import blkdma_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              busy,
    output logic [31:0]       rd_data,
    output mode_t             mode_o,
    output logic [ADDR_W-1:0] base_o,
    output logic              start_o,
    output logic              hold_o
);

    mode_t       mode_q;
    logic [31:0] lo_q;
    logic [31:0] hi_q;
    logic [1:0]  rst_q;
    logic [63:0] full_addr;

    // Register writes; the channel-reset pair powers up released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            rst_q  <= 2'b11;
        end else if (wr_en) begin
            case (wr_addr)
                REG_MODE: mode_q <= '{dir: wr_data[17:16], width: wr_data[5:4], inc: wr_data[0]};
                REG_RST:  rst_q  <= wr_data[9:8];
                REG_LO:   lo_q   <= wr_data;
                REG_HI:   hi_q   <= wr_data;
                default:  ;
            endcase
        end
    end

    // Read multiplexer; start bit never reads back as set.
    always_comb begin
        case (wr_addr)
            REG_MODE: rd_data = {14'b0, mode_q.dir, 10'b0, mode_q.width, 3'b0, mode_q.inc};
            REG_CTRL: rd_data = {30'b0, busy, 1'b0};
            REG_RST:  rd_data = {22'b0, rst_q, 8'b0};
            REG_LO:   rd_data = lo_q;
            REG_HI:   rd_data = hi_q;
            default:  rd_data = '0;
        endcase
    end

    assign full_addr = {hi_q, lo_q};
    assign base_o    = full_addr[ADDR_W-1:0];
    assign mode_o    = mode_q;
    assign start_o   = wr_en && (wr_addr == REG_CTRL) && wr_data[0];
    assign hold_o    = !(rst_q[0] && rst_q[1]);

endmodule

// File: rtl/blkdma_addr_gen.sv
// Address generator: loads the start address aligned down to the beat
// size, then steps it by the beat size (or not at all) per memory beat.
// Assumes load and step never occur in the same cycle.
module blkdma_addr_gen #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        load_width,
    input  logic              step,
    input  logic [1:0]        step_width,
    input  logic              step_inc,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] align_mask;
    logic [ADDR_W-1:0] stride;

    // Mask clears the bits below the beat size of the new transfer.
    assign align_mask = ~((ADDR_W'(1) << load_width) - ADDR_W'(1));
    // Stride is the beat size in bytes, zero for a fixed address.
    assign stride     = step_inc ? (ADDR_W'(1) << step_width) : '0;

    // Current beat address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= base & align_mask;
        end else if (step) begin
            addr <= addr + stride;
        end
    end

endmodule

// File: rtl/blkdma_seq.sv
// Beat sequencer: latches the mode at start, counts beats and walks the
// memory and FIFO handshakes in the latched direction. A hold forces idle
// with no done. Assumes DATA_W holds the widest (64-bit) beat.
module blkdma_seq
    import blkdma_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BSZ_W  = 12,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              hold,
    input  mode_t             mode,
    input  logic [CNT_W-1:0]  blk_count,
    input  logic [BSZ_W-1:0]  blk_size,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              fifo_out_ready,
    input  logic              fifo_in_valid,
    input  logic [DATA_W-1:0] fifo_in_data,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] beat_data,
    output logic              fifo_out_valid,
    output logic              fifo_in_ready,
    output logic              load,
    output logic              step,
    output logic [1:0]        lat_width,
    output logic              lat_inc
);

    localparam int LEN_W = CNT_W + BSZ_W;

    seq_state_t       state;
    logic [LEN_W-1:0] total_bytes;
    logic [LEN_W-1:0] beats;
    logic [LEN_W-1:0] remaining;
    logic             last_beat;
    logic             dir_in;

    // Length of the new transfer in beats.
    assign total_bytes = LEN_W'(blk_count) * LEN_W'(blk_size);
    assign beats       = total_bytes >> mode.width;
    assign last_beat   = (remaining == LEN_W'(1));
    assign dir_in      = (mode.dir == 2'b01);

    // Transfer state, beat counter, latched mode and beat buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            remaining <= '0;
            done      <= 1'b0;
            beat_data <= '0;
            lat_width <= '0;
            lat_inc   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (hold) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (start) begin
                            lat_width <= mode.width;
                            lat_inc   <= mode.inc;
                            remaining <= beats;
                            if (beats == '0) begin
                                done <= 1'b1;
                            end else begin
                                state <= dir_in ? ST_PULL : ST_RD_REQ;
                            end
                        end
                    end
                    ST_RD_REQ: begin
                        if (mem_ack) begin
                            beat_data <= mem_rdata;
                            state     <= ST_PUSH;
                        end
                    end
                    ST_PUSH: begin
                        if (fifo_out_ready) begin
                            remaining <= remaining - LEN_W'(1);
                            if (last_beat) begin
                                done  <= 1'b1;
                                state <= ST_IDLE;
                            end else begin
                                state <= ST_RD_REQ;
                            end
                        end
                    end
                    ST_PULL: begin
                        if (fifo_in_valid) begin
                            beat_data <= fifo_in_data;
                            state     <= ST_WR_REQ;
                        end
                    end
                    ST_WR_REQ: begin
                        if (mem_ack) begin
                            remaining <= remaining - LEN_W'(1);
                            if (last_beat) begin
                                done  <= 1'b1;
                                state <= ST_IDLE;
                            end else begin
                                state <= ST_PULL;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Handshake outputs decoded from the state.
    assign busy           = (state != ST_IDLE);
    assign mem_req        = (state == ST_RD_REQ) || (state == ST_WR_REQ);
    assign mem_we         = (state == ST_WR_REQ);
    assign fifo_out_valid = (state == ST_PUSH);
    assign fifo_in_ready  = (state == ST_PULL);
    assign load           = (state == ST_IDLE) && start && !hold;
    assign step           = mem_req && mem_ack && !hold;

endmodule

// File: rtl/blkdma_chan.sv
// Top: single-segment DMA channel. Wires the register file, the beat
// sequencer and the address generator together. Assumes one transfer at
// a time; the memory port completes each request with a single ack.
module blkdma_chan
    import blkdma_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64,
    parameter int CNT_W  = 16,
    parameter int BSZ_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [CNT_W-1:0]  blk_count,
    input  logic [BSZ_W-1:0]  blk_size,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              fifo_out_valid,
    input  logic              fifo_out_ready,
    output logic [DATA_W-1:0] fifo_out_data,
    input  logic              fifo_in_valid,
    output logic              fifo_in_ready,
    input  logic [DATA_W-1:0] fifo_in_data,
    output logic              done,
    output logic              busy
);

    mode_t             mode;
    logic [ADDR_W-1:0] base;
    logic              start;
    logic              chan_hold;
    logic              load;
    logic              step;
    logic [1:0]        lat_width;
    logic              lat_inc;
    logic [DATA_W-1:0] beat_data;

    blkdma_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .busy    (busy),
        .rd_data (reg_rdata),
        .mode_o  (mode),
        .base_o  (base),
        .start_o (start),
        .hold_o  (chan_hold)
    );

    blkdma_seq #(.CNT_W(CNT_W), .BSZ_W(BSZ_W), .DATA_W(DATA_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .hold           (chan_hold),
        .mode           (mode),
        .blk_count      (blk_count),
        .blk_size       (blk_size),
        .mem_ack        (mem_ack),
        .mem_rdata      (mem_rdata),
        .fifo_out_ready (fifo_out_ready),
        .fifo_in_valid  (fifo_in_valid),
        .fifo_in_data   (fifo_in_data),
        .busy           (busy),
        .done           (done),
        .mem_req        (mem_req),
        .mem_we         (mem_we),
        .beat_data      (beat_data),
        .fifo_out_valid (fifo_out_valid),
        .fifo_in_ready  (fifo_in_ready),
        .load           (load),
        .step           (step),
        .lat_width      (lat_width),
        .lat_inc        (lat_inc)
    );

    blkdma_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .base       (base),
        .load_width (mode.width),
        .step       (step),
        .step_width (lat_width),
        .step_inc   (lat_inc),
        .addr       (mem_addr)
    );

    assign mem_size      = lat_width;
    assign mem_wdata     = beat_data;
    assign fifo_out_data = beat_data;

endmodule

// File: rtl/blkdma_chan_chk.sv
// Checker: protocol and control properties of the DMA channel, bound to
// the top module. Assumes synchronous active-low reset.
module blkdma_chan_chk #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chan_hold,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              fifo_out_valid,
    input logic              fifo_out_ready,
    input logic [DATA_W-1:0] fifo_out_data,
    input logic              fifo_in_ready
);

    assert_req_stable_R8: assert property (@(posedge clk) disable iff (!rst_n || chan_hold)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    assert_out_stable_R8: assert property (@(posedge clk) disable iff (!rst_n || chan_hold)
        fifo_out_valid && !fifo_out_ready |=> fifo_out_valid && $stable(fifo_out_data));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        chan_hold |=> !busy && !done);

    assert_single_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, fifo_out_valid, fifo_in_ready}));

endmodule

bind blkdma_chan blkdma_chan_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .chan_hold      (chan_hold),
    .busy           (busy),
    .done           (done),
    .mem_req        (mem_req),
    .mem_ack        (mem_ack),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .fifo_out_valid (fifo_out_valid),
    .fifo_out_ready (fifo_out_ready),
    .fifo_out_data  (fifo_out_data),
    .fifo_in_ready  (fifo_in_ready)
);

// File: tb/blkdma_chan_tb.sv
`timescale 1ns/1ps
module blkdma_chan_tb;

    localparam int ADDR_W = 64;
    localparam int DATA_W = 64;
    localparam int CNT_W  = 16;
    localparam int BSZ_W  = 12;
    localparam int LOGN   = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [CNT_W-1:0]  blk_count = '0;
    logic [BSZ_W-1:0]  blk_size = '0;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [1:0]        mem_size;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic              mem_ack = 1'b0;
    logic              fifo_out_valid;
    logic              fifo_out_ready = 1'b0;
    logic [DATA_W-1:0] fifo_out_data;
    logic              fifo_in_valid = 1'b0;
    logic              fifo_in_ready;
    logic [DATA_W-1:0] fifo_in_data = '0;
    logic              done, busy;

    int n_chk = 0;
    int n_fail = 0;

    int          log_n = 0, out_n = 0, in_n = 0, done_cnt = 0, cyc = 0;
    int          lat_cnt = 0, cur_lat = 0;
    logic [63:0] log_addr [LOGN];
    logic [1:0]  log_size [LOGN];
    logic        log_we   [LOGN];
    logic [63:0] log_wdat [LOGN];
    logic [63:0] out_dat  [LOGN];

    blkdma_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .BSZ_W(BSZ_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .blk_count(blk_count),
        .blk_size(blk_size), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .fifo_out_valid(fifo_out_valid), .fifo_out_ready(fifo_out_ready),
        .fifo_out_data(fifo_out_data), .fifo_in_valid(fifo_in_valid),
        .fifo_in_ready(fifo_in_ready), .fifo_in_data(fifo_in_data), .done(done), .busy(busy)
    );

    always #2.5 clk = ~clk;

    function automatic logic [63:0] mem_pat(input logic [63:0] a);
        return {a[31:0] ^ 32'hA5A5_0000, ~a[31:0]};
    endfunction

    function automatic logic [63:0] src_pat(input int i);
        return {32'hC0DE_0000 | 32'(i), 32'(i) * 32'd3};
    endfunction

    assign mem_rdata = mem_pat(mem_addr);

    // Memory model, FIFO sink and FIFO source, all driven at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst_n) begin
                mem_ack = 1'b0; fifo_out_ready = 1'b0; fifo_in_valid = 1'b0;
            end else begin
                if (mem_req) begin
                    if (lat_cnt >= cur_lat) begin
                        mem_ack = 1'b1;
                        if (log_n < LOGN) begin
                            log_addr[log_n] = mem_addr; log_size[log_n] = mem_size;
                            log_we[log_n] = mem_we; log_wdat[log_n] = mem_wdata;
                        end
                        log_n++;
                        lat_cnt = 0;
                        cur_lat = (cur_lat + 1) % 3;
                    end else begin
                        mem_ack = 1'b0;
                        lat_cnt++;
                    end
                end else begin
                    mem_ack = 1'b0;
                    lat_cnt = 0;
                end
                fifo_out_ready = (cyc % 4) != 1;
                if (fifo_out_valid && fifo_out_ready) begin
                    if (out_n < LOGN) out_dat[out_n] = fifo_out_data;
                    out_n++;
                end
                if (fifo_in_ready && (cyc % 3) != 2) begin
                    fifo_in_valid = 1'b1;
                    fifo_in_data  = src_pat(in_n);
                    in_n++;
                end else begin
                    fifo_in_valid = 1'b0;
                end
                if (done) done_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_done(output bit seen);
        int t = 0;
        while (!done && t < 6000) begin
            @(negedge clk);
            t++;
        end
        seen = done;
    endtask

    // One transfer with full beat-by-beat comparison.
    task automatic run_xfer(input logic [1:0] dfield, input logic [1:0] w, input logic inc,
                            input logic [63:0] base, input int cnt, input int bsz,
                            input bit disturb);
        int          beats = (cnt * bsz) >> w;
        bit          din = (dfield == 2'b01);
        logic [63:0] bal = base & ~((64'd1 << w) - 64'd1);
        logic [31:0] r;
        bit          seen;
        int          m0, o0, i0, d0;
        blk_count = CNT_W'(cnt);
        blk_size  = BSZ_W'(bsz);
        wr_reg(3'd0, {14'b0, dfield, 10'b0, w, 3'b0, inc});
        wr_reg(3'd3, base[31:0]);
        wr_reg(3'd4, base[63:32]);
        m0 = log_n; o0 = out_n; i0 = in_n; d0 = done_cnt;
        wr_reg(3'd1, 32'h1);
        rd_reg(3'd1, r);
        chk(r[1] == 1'b1, "R6", "busy bit after start", 64'(r[1]), 64'd1);
        chk(r[0] == 1'b0, "R6", "start bit reads back", 64'(r[0]), 64'd0);
        if (disturb) begin
            // R7: second start plus new mode and address while running
            wr_reg(3'd1, 32'h1);
            wr_reg(3'd3, 32'h0000_4000);
            wr_reg(3'd0, 32'h0001_0031);
        end
        wait_done(seen);
        chk(seen && !busy, "R9", "done with busy low", {62'b0, seen, busy}, 64'd2);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done one cycle", 64'(done), 64'd0);
        repeat (8) @(negedge clk);
        chk(done_cnt - d0 == 1, "R7", "done count per start", 64'(done_cnt - d0), 64'd1);
        chk(log_n - m0 == beats, "R8", "memory accesses per transfer", 64'(log_n - m0), 64'(beats));
        if (din)
            chk(in_n - i0 == beats, "R2", "FIFO input beats", 64'(in_n - i0), 64'(beats));
        else
            chk(out_n - o0 == beats, "R2", "FIFO output beats", 64'(out_n - o0), 64'(beats));
        for (int i = 0; i < beats; i++) begin
            logic [63:0] ea = bal + (inc ? (64'(i) << w) : 64'd0);
            if (m0 + i < LOGN) begin
                chk(log_addr[m0+i] == ea, inc ? "R4" : "R5", "beat address", log_addr[m0+i], ea);
                chk(log_size[m0+i] == w, "R3", "beat size code", 64'(log_size[m0+i]), 64'(w));
                chk(log_we[m0+i] == din, "R2", "access direction", 64'(log_we[m0+i]), 64'(din));
                if (din)
                    chk(log_wdat[m0+i] == src_pat(i0 + i), "R2", "write data", log_wdat[m0+i], src_pat(i0 + i));
                else if (o0 + i < LOGN)
                    chk(out_dat[o0+i] == mem_pat(ea), "R2", "FIFO data", out_dat[o0+i], mem_pat(ea));
            end
        end
    endtask

    initial begin
        #750000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int          d0, m0;
        bit          seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(!mem_req && !fifo_out_valid && !done && !busy, "R1", "idle outputs",
            {60'b0, mem_req, fifo_out_valid, done, busy}, 64'd0);
        rd_reg(3'd0, r); chk(r == 32'h0, "R1", "mode after reset", 64'(r), 64'h0);
        rd_reg(3'd1, r); chk(r == 32'h0, "R1", "ctrl after reset", 64'(r), 64'h0);
        rd_reg(3'd2, r); chk(r == 32'h300, "R1", "reset reg after reset", 64'(r), 64'h300);

        // R3: only defined mode bits are stored
        wr_reg(3'd0, 32'hFFFF_FFFF);
        rd_reg(3'd0, r); chk(r == 32'h0003_0031, "R3", "mode read mask", 64'(r), 64'h0003_0031);

        // Sweep: both directions, all widths, fixed and stepping address (R2-R5)
        for (int d = 0; d < 2; d++)
            for (int w = 0; w < 4; w++)
                for (int inc = 0; inc < 2; inc++)
                    run_xfer(2'(d), 2'(w), 1'(inc), 64'h0000_0001_8000_0107, 2, 16, 1'b0);

        // R2: direction code 2 behaves as memory to FIFO
        run_xfer(2'd2, 2'd3, 1'b1, 64'h0000_0002_0000_0040, 1, 32, 1'b0);

        // R7: disturbance while running
        run_xfer(2'd0, 2'd0, 1'b1, 64'h0000_0000_1000_0000, 2, 16, 1'b1);
        run_xfer(2'd1, 2'd1, 1'b1, 64'h0000_0000_2000_0002, 4, 8, 1'b1);

        // R10: zero-length transfer
        blk_count = '0; blk_size = 12'd64;
        m0 = log_n; d0 = done_cnt;
        wr_reg(3'd1, 32'h1);
        chk(done && !busy, "R10", "done after zero start", {62'b0, done, busy}, 64'd2);
        repeat (6) @(negedge clk);
        chk(log_n == m0, "R10", "no memory access", 64'(log_n - m0), 64'd0);
        chk(done_cnt - d0 == 1, "R10", "single done", 64'(done_cnt - d0), 64'd1);

        // R11: abort a long transfer
        blk_count = 16'd4; blk_size = 12'd512;
        wr_reg(3'd0, 32'h0000_0001);
        wr_reg(3'd3, 32'h0000_8000);
        wr_reg(3'd1, 32'h1);
        repeat (20) @(negedge clk);
        chk(busy == 1'b1, "R11", "busy before abort", 64'(busy), 64'd1);
        d0 = done_cnt;
        wr_reg(3'd2, 32'h0);
        @(negedge clk);
        chk(!busy && !mem_req && !fifo_out_valid, "R11", "idle after hold",
            {61'b0, busy, mem_req, fifo_out_valid}, 64'd0);
        wr_reg(3'd1, 32'h1);
        @(negedge clk);
        chk(!busy, "R11", "start ignored while held", 64'(busy), 64'd0);
        rd_reg(3'd2, r); chk(r == 32'h0, "R11", "reset reg held", 64'(r), 64'h0);
        wr_reg(3'd2, 32'h200);
        wr_reg(3'd1, 32'h1);
        @(negedge clk);
        chk(!busy, "R11", "start ignored with one bit clear", 64'(busy), 64'd0);
        repeat (10) @(negedge clk);
        chk(done_cnt == d0, "R11", "no done after abort", 64'(done_cnt - d0), 64'd0);
        wr_reg(3'd2, 32'h300);
        run_xfer(2'd1, 2'd2, 1'b1, 64'h0000_0003_0000_0010, 1, 32, 1'b0);
        run_xfer(2'd0, 2'd3, 1'b0, 64'h0000_0003_0000_0018, 1, 32, 1'b0);

        wait_done(seen);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule